// File: doc/BRIEF.md
# Segment-and-Page Address Walker

This block turns a virtual address into a physical address by walking two tables in a shared table memory. The virtual address holds three fields. From the top bit down they are a segment number, a page number and a word displacement. Segments are made of fixed-size pages, and each segment may own a different number of pages.

The walk has two table reads. The segment number selects an entry in the segment table. That entry gives the base of the segment's own page table, the number of pages the segment owns and a valid bit. If the page number is inside the segment, the walker reads the page table at base plus page number. The page entry gives a frame number and a valid bit. The physical address is the frame's base address plus the word displacement.

The walker reads the table memory through one synchronous read port with a latency of one cycle. It accepts a request only while idle. When the walk ends, done pulses for one cycle, either with the physical address or with one fault flag.

Top module: `seg_page_walker`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, busy_o, done_o, mem_rd_o, pa_o and all three fault outputs are 0.
- R2: The virtual address fields are split as follows:
  - segment: bits [8:7]
  - page: bits [6:4]
  - word: bits [3:0]

  The segment entry is read at address SEG_BASE + segment. This read is issued in the same cycle that an idle walker sees req_i.
- R3: Each segment entry encodes three fields:
  - bits [7:0]: page-table base
  - bits [11:8]: page count
  - bit 15: valid

  When the segment entry is valid and in range, the second read goes to page-table base + page, in the following cycle.
- R4: A page entry encodes the frame in bits [5:0] and a valid bit in bit 15. A successful walk returns pa_o = frame*16 + word, with done_o high in the third cycle after the accepting clock edge.
- R5: If the segment valid bit is clear, seg_fault_o is raised with done_o in the second cycle after acceptance, and no page-table read is made.
- R6: If page >= page count, range_fault_o is raised with done_o in the second cycle after acceptance, and no page-table read is made. A count of 0 makes every page out of range.
- R7: If the page valid bit is clear, page_fault_o is raised with done_o in the third cycle after acceptance.
- R8: A segment fault has priority over a range fault. At most one fault flag is set at a time, and pa_o is 0 when a fault is reported.
- R9: done_o is high for exactly one cycle per walk. The walker is idle again in the next cycle.
- R10: While busy_o is high, req_i and va_i are ignored. The result belongs to the address that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Translation request, taken only when idle |
| va_i | input | 9 | Virtual address {segment, page, word} |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 10 | Physical address, valid with done_o |
| seg_fault_o | output | 1 | Segment not present |
| page_fault_o | output | 1 | Page not present |
| range_fault_o | output | 1 | Page number beyond segment's page count |
| mem_rd_o | output | 1 | Table memory read enable |
| mem_addr_o | output | 8 | Table memory read address |
| mem_rdata_i | input | 16 | Table memory read data, one cycle after mem_rd_o |

## Verification
The segment-valid check and the page-range check are decided in the same cycle, from the same segment entry. The bench programs one segment as invalid with a page count of 1, so that every page number above 0 trips both conditions at once. For those addresses it expects only seg_fault_o, the short two-cycle latency and a single table read.

The bench also keeps req_i high with a changing address through some walks. This places a new request in the same cycles as an ongoing walk. The result is then judged against the address that was accepted first.

// File: rtl/spw_pkg.sv
package spw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEG,
    ST_PAGE,
    ST_DONE
  } spw_state_e;

  typedef struct packed {
    logic seg;
    logic page;
    logic range;
  } spw_fault_t;
endpackage

// File: rtl/spw_seg_check.sv
module spw_seg_check #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TADDR_W = 8,
  parameter int unsigned PAGE_W  = 3
) (
  input  logic [DATA_W-1:0]  entry_i,
  input  logic [PAGE_W-1:0]  page_i,
  output logic               valid_o,
  output logic               in_range_o,
  output logic [TADDR_W-1:0] pt_addr_o
);
  localparam int unsigned CNT_W = PAGE_W + 1;

  logic [CNT_W-1:0] cnt;

  assign cnt        = entry_i[TADDR_W +: CNT_W];
  assign valid_o    = entry_i[DATA_W-1];
  assign in_range_o = {1'b0, page_i} < cnt;
  assign pt_addr_o  = entry_i[TADDR_W-1:0] + TADDR_W'(page_i);
endmodule

// File: rtl/spw_page_form.sv
module spw_page_form #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 6,
  parameter int unsigned WORD_W  = 4,
  parameter int unsigned PA_W    = FRAME_W + WORD_W
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [PA_W-1:0]   pa_o
);
  logic [PA_W-1:0] frame_base;

  assign valid_o    = entry_i[DATA_W-1];
  assign frame_base = {entry_i[FRAME_W-1:0], {WORD_W{1'b0}}};
  assign pa_o       = frame_base + PA_W'(word_i);
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
  import spw_pkg::*;
#(
  parameter int unsigned SEG_W    = 2,
  parameter int unsigned PAGE_W   = 3,
  parameter int unsigned WORD_W   = 4,
  parameter int unsigned FRAME_W  = 6,
  parameter int unsigned TADDR_W  = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SEG_BASE = 0,
  localparam int unsigned VA_W    = SEG_W + PAGE_W + WORD_W,
  localparam int unsigned PA_W    = FRAME_W + WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [VA_W-1:0]    va_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [PA_W-1:0]    pa_o,
  output logic               seg_fault_o,
  output logic               page_fault_o,
  output logic               range_fault_o,
  output logic               mem_rd_o,
  output logic [TADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  spw_state_e          state_q, state_d;
  logic [SEG_W-1:0]    seg_in;
  logic [PAGE_W-1:0]   page_q;
  logic [WORD_W-1:0]   word_q;
  logic [PA_W-1:0]     pa_q;
  spw_fault_t          fault_q;
  logic                accept;
  logic                seg_valid, seg_in_range, pg_valid;
  logic [TADDR_W-1:0]  pt_addr;
  logic [PA_W-1:0]     pa_new;

  assign seg_in = va_i[VA_W-1 -: SEG_W];
  assign accept = (state_q == ST_IDLE) && req_i;

  spw_seg_check #(
    .DATA_W (DATA_W),
    .TADDR_W(TADDR_W),
    .PAGE_W (PAGE_W)
  ) u_seg_check (
    .entry_i   (mem_rdata_i),
    .page_i    (page_q),
    .valid_o   (seg_valid),
    .in_range_o(seg_in_range),
    .pt_addr_o (pt_addr)
  );

  spw_page_form #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .WORD_W (WORD_W),
    .PA_W   (PA_W)
  ) u_page_form (
    .entry_i(mem_rdata_i),
    .word_i (word_q),
    .valid_o(pg_valid),
    .pa_o   (pa_new)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_SEG;
      ST_SEG:  state_d = (seg_valid && seg_in_range) ? ST_PAGE : ST_DONE;
      ST_PAGE: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      word_q  <= '0;
      pa_q    <= '0;
      fault_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        page_q  <= va_i[WORD_W +: PAGE_W];
        word_q  <= va_i[WORD_W-1:0];
        pa_q    <= '0;
        fault_q <= '0;
      end
      if (state_q == ST_SEG) begin
        // segment absence outranks range check
        if (!seg_valid)         fault_q.seg   <= 1'b1;
        else if (!seg_in_range) fault_q.range <= 1'b1;
      end
      if (state_q == ST_PAGE) begin
        if (pg_valid) pa_q <= pa_new;
        else          fault_q.page <= 1'b1;
      end
    end
  end

  assign mem_rd_o   = accept || ((state_q == ST_SEG) && seg_valid && seg_in_range);
  assign mem_addr_o = (state_q == ST_IDLE) ? TADDR_W'(SEG_BASE) + TADDR_W'(seg_in) : pt_addr;

  assign busy_o        = state_q != ST_IDLE;
  assign done_o        = state_q == ST_DONE;
  assign pa_o          = done_o ? pa_q : '0;
  assign seg_fault_o   = done_o && fault_q.seg;
  assign page_fault_o  = done_o && fault_q.page;
  assign range_fault_o = done_o && fault_q.range;

  AST_RESET_QUIET: assert property (@(posedge clk_i) $rose(rst_ni) |-> !busy_o && !done_o) // R1
    else $error("reset state");
  AST_SEG_READ_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mem_rd_o)) // R2
    else $error("no segment read at accept");
  AST_NO_PAGE_READ_ON_SEG_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_fault_o || range_fault_o) |-> !$past(mem_rd_o)) // R5
    else $error("page read despite segment-level fault");
  AST_ONE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({seg_fault_o, page_fault_o, range_fault_o}) <= 1) // R8
    else $error("multiple faults");
  AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_fault_o || page_fault_o || range_fault_o) |-> pa_o == '0) // R8
    else $error("pa with fault");
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o) // R9
    else $error("done not a pulse");
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o) // R10
    else $error("walk cut short");
endmodule

// File: tb/seg_page_walker_bench.sv
`timescale 1ns/1ps
module seg_page_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [8:0]  va = '0;
  logic        busy, done, seg_f, page_f, rng_f, mem_rd;
  logic [9:0]  pa;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt;
  int rd_addr [2];

  always #2 clk = ~clk;

  seg_page_walker u_seg_page_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va),
    .busy_o(busy), .done_o(done), .pa_o(pa),
    .seg_fault_o(seg_f), .page_fault_o(page_f), .range_fault_o(rng_f),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      if (rd_cnt < 2) rd_addr[rd_cnt] = int'(mem_addr);
      rd_cnt = rd_cnt + 1;
      mem_rdata <= mem[mem_addr];
    end
  end

  function automatic int seg_cnt(input int s);
    case (s)
      0: return 8;
      1: return 3;
      2: return 1;
      default: return 5;
    endcase
  endfunction
  function automatic bit seg_ok(input int s);
    return s != 2;
  endfunction
  function automatic int pt_base(input int s);
    return 'h40 + s * 16;
  endfunction
  function automatic int frame_of(input int s, input int p);
    return (s * 13 + p * 5 + 1) % 64;
  endfunction
  function automatic bit pg_ok(input int s, input int p);
    return ((s * 8 + p) % 5) != 2;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic walk(input int v, input bit hold, input int alt);
    int s = v >> 7;
    int p = (v >> 4) & 7;
    int d = v & 15;
    int kind; // 0 ok, 1 seg, 2 range, 3 page
    int exp_lat, exp_pa, lat;
    bit got;
    if (!seg_ok(s))           kind = 1;
    else if (p >= seg_cnt(s)) kind = 2;
    else if (!pg_ok(s, p))    kind = 3;
    else                      kind = 0;
    exp_lat = (kind == 1 || kind == 2) ? 2 : 3;
    exp_pa  = (kind == 0) ? frame_of(s, p) * 16 + d : 0;
    @(negedge clk);
    rd_cnt = 0;
    req = 1'b1;
    va  = 9'(v);
    @(posedge clk);
    lat = 0;
    got = 1'b0;
    while (!got && lat < 8) begin
      @(negedge clk);
      lat++;
      if (lat == 1) check(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
      if (hold) va = 9'(alt);
      else      req = 1'b0;
      if (done) begin
        got = 1'b1;
        req = 1'b0;
      end
    end
    check(lat == exp_lat, kind == 1 ? "R5 latency" : kind == 2 ? "R6 latency" : "R4 latency", lat, exp_lat);
    check(int'(pa) == exp_pa, hold ? "R10 pa of accepted address" : "R4 pa", int'(pa), exp_pa);
    check(seg_f == (kind == 1), "R5 seg fault", int'(seg_f), int'(kind == 1));
    check(rng_f == (kind == 2), "R8 R6 range fault", int'(rng_f), int'(kind == 2));
    check(page_f == (kind == 3), "R7 page fault", int'(page_f), int'(kind == 3));
    check(rd_cnt == exp_lat - 1, "R5 R6 table read count", rd_cnt, exp_lat - 1);
    check(rd_addr[0] == s, "R2 segment entry address", rd_addr[0], s);
    if (exp_lat == 3)
      check(rd_addr[1] == pt_base(s) + p, "R3 page entry address", rd_addr[1], pt_base(s) + p);
    @(negedge clk);
    check(!done && !busy, "R9 done pulse", int'(done) + 2 * int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rd_cnt = 0;
    rd_addr[0] = 0;
    rd_addr[1] = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int s = 0; s < 4; s++) begin
      mem[s] = {seg_ok(s), 3'b000, 4'(seg_cnt(s)), 8'(pt_base(s))};
      for (int p = 0; p < 8; p++)
        mem[pt_base(s) + p] = {pg_ok(s, p), 9'b0, 6'(frame_of(s, p))};
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd && pa == '0 && !seg_f && !page_f && !rng_f,
          "R1 reset outputs", int'(busy) + int'(done) + int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_rd, "R1 after release", int'(busy) + int'(done), 0);
    for (int v = 0; v < 512; v++) walk(v, (v % 7) == 0, (v * 37 + 11) % 512);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule